// File: doc/BRIEF.md
# Embedded-Controller Host Port

This block is the controller end of a byte-wide, two-port host interface in the ACPI embedded-controller style. The host sees a data port (port select 0) and a combined status/command port (port select 1): reading port 1 returns a status byte, and writing port 1 issues a command. Commands open short handshakes. In a read handshake the host sends one address byte and then collects the addressed byte from the data port. In a write handshake the host sends an address byte and then a data byte, which the controller stores. Both handshakes reach an internal register space of 2^ADDR_W bytes.

Two flags pace the host. The input-full flag (IBF) is set when the host writes a byte. It stays set for a fixed processing delay, and then the controller consumes the byte and clears the flag. The output-full flag (OBF) is set when the controller places a byte in the data register, and it clears when the host reads the data port. The burst-enable, burst-disable and query commands are handled only as flag changes or as fixed replies. Event signalling to the host is not generated, so its status bits always read zero.

Top module: `ecHostPort`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00, and every byte of the register space holds 0x00.
- R2: A host write to either port, made while IBF is clear, sets IBF (status bit 1) on the next cycle. The same write sets status bit 3 to 1 if it went to the command port and to 0 if it went to the data port.
- R3: IBF stays set for exactly PROC_DELAY cycles after the accepting clock edge and then clears. A host write made while IBF is set is dropped and changes nothing.
- R4: Command 0x80 followed by an address byte loads the addressed register into the data register and sets OBF (status bit 0) in the cycle that IBF clears.
- R5: Command 0x81 followed by an address byte and then a data byte stores that data byte at that address.
- R6: A host read of the data port clears OBF. A read of the status port leaves OBF unchanged.
- R7: Command 0x82 sets the burst bit (status bit 4), loads 0x90 into the data register and sets OBF. Command 0x83 clears the burst bit and leaves OBF unchanged.
- R8: Command 0x84 loads 0x00 into the data register and sets OBF.
- R9: A data byte that arrives when no command is in progress is ignored: OBF stays clear and the register space is unchanged.
- R10: Any command ends an unfinished handshake. A command code other than 0x80 to 0x84 ends it too and starts nothing new, so later data bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe, one cycle per byte |
| portSel | input | 1 | 0 selects the data port, 1 selects the status/command port |
| hostWdata | input | 8 | Byte written by the host |
| hostRdata | output | 8 | Status byte when portSel is 1, data register when portSel is 0 |

## Verification
On every cycle, the bound checker enforces the flag timing. It checks that an accepted write raises IBF and records the port in status bit 3. It checks that IBF never outlives PROC_DELAY cycles and drops exactly at that limit. It also checks that OBF rises only as IBF falls, that a data-port read clears OBF, and that the burst bit moves only while a byte is being consumed. The handshake meaning cannot be seen by a property, and only the bench's command sequences show it: stored bytes coming back at the right addresses, the fixed replies to burst-enable and query, stray data being ignored, and commands that end half-finished handshakes.

// File: rtl/ecHostPortPkg.sv
package ecHostPortPkg;
  localparam logic [7:0] CMD_READ   = 8'h80;
  localparam logic [7:0] CMD_WRITE  = 8'h81;
  localparam logic [7:0] CMD_BURSTON  = 8'h82;
  localparam logic [7:0] CMD_BURSTOFF = 8'h83;
  localparam logic [7:0] CMD_QUERY  = 8'h84;
  localparam logic [7:0] BURST_ACK  = 8'h90;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_WR_ADDR,
    ST_WR_DATA
  } hsStateT;

  typedef struct packed {
    logic       clrIbf;
    logic       latchAddr;
    logic       memWrite;
    logic       loadMem;
    logic       loadConst;
    logic [7:0] constByte;
    logic       burstSet;
    logic       burstClr;
  } dpStrobeT;
endpackage

// File: rtl/ecDatapath.sv
module ecDatapath
  import ecHostPortPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       portSel,
  input  logic [7:0] hostWdata,
  input  dpStrobeT   strobe,
  output logic [7:0] inByte,
  output logic       cmdFlag,
  output logic       ibf,
  output logic [7:0] statusByte,
  output logic [7:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        regSpace [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic              obf;
  logic              burst;
  logic [ADDR_W-1:0] inAddr;

  assign inAddr = inByte[ADDR_W-1:0];

  // host-facing input latch and IBF
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inByte  <= '0;
      cmdFlag <= 1'b0;
      ibf     <= 1'b0;
    end else if (hostWr && !ibf) begin
      inByte  <= hostWdata;
      cmdFlag <= portSel;
      ibf     <= 1'b1;
    end else if (strobe.clrIbf) begin
      ibf <= 1'b0;
    end
  end

  // output register and OBF
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      obf     <= 1'b0;
    end else if (strobe.loadMem) begin
      dataOut <= regSpace[inAddr];
      obf     <= 1'b1;
    end else if (strobe.loadConst) begin
      dataOut <= strobe.constByte;
      obf     <= 1'b1;
    end else if (hostRd && !portSel) begin
      obf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      burst   <= 1'b0;
    end else begin
      if (strobe.latchAddr) addrReg <= inAddr;
      if (strobe.burstSet) burst <= 1'b1;
      else if (strobe.burstClr) burst <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regSpace[i] <= '0;
    end else if (strobe.memWrite) begin
      regSpace[addrReg] <= inByte;
    end
  end

  // bit 0 OBF, bit 1 IBF, bit 3 last byte was a command, bit 4 burst
  assign statusByte = {3'b000, burst, cmdFlag, 1'b0, ibf, obf};
endmodule

// File: rtl/ecControl.sv
module ecControl
  import ecHostPortPkg::*;
#(
  parameter int PROC_DELAY = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ibf,
  input  logic       cmdFlag,
  input  logic [7:0] inByte,
  output dpStrobeT   strobe
);
  localparam int CNT_W = $clog2(PROC_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROC_DELAY - 1);

  hsStateT         state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic            fire;

  assign fire = ibf && (waitCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      state   <= ST_IDLE;
    end else begin
      state <= nextState;
      if (fire || !ibf) waitCnt <= '0;
      else waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (fire) begin
      strobe.clrIbf = 1'b1;
      if (cmdFlag) begin
        nextState = ST_IDLE;
        case (inByte)
          CMD_READ:     nextState = ST_RD_ADDR;
          CMD_WRITE:    nextState = ST_WR_ADDR;
          CMD_BURSTON: begin
            strobe.burstSet  = 1'b1;
            strobe.loadConst = 1'b1;
            strobe.constByte = BURST_ACK;
          end
          CMD_BURSTOFF: strobe.burstClr = 1'b1;
          CMD_QUERY: begin
            strobe.loadConst = 1'b1;
            strobe.constByte = 8'h00;
          end
          default: nextState = ST_IDLE;
        endcase
      end else begin
        case (state)
          ST_RD_ADDR: begin
            strobe.loadMem = 1'b1;
            nextState      = ST_IDLE;
          end
          ST_WR_ADDR: begin
            strobe.latchAddr = 1'b1;
            nextState        = ST_WR_DATA;
          end
          ST_WR_DATA: begin
            strobe.memWrite = 1'b1;
            nextState       = ST_IDLE;
          end
          default: nextState = ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecHostPort.sv
module ecHostPort
  import ecHostPortPkg::*;
#(
  parameter int PROC_DELAY = 3,
  parameter int ADDR_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       portSel,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata
);
  dpStrobeT   strobe;
  logic [7:0] inByte;
  logic       cmdFlag;
  logic       ibf;
  logic [7:0] statusByte;
  logic [7:0] dataOut;

  ecDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .portSel(portSel), .hostWdata(hostWdata), .strobe(strobe),
    .inByte(inByte), .cmdFlag(cmdFlag), .ibf(ibf),
    .statusByte(statusByte), .dataOut(dataOut)
  );

  ecControl #(.PROC_DELAY(PROC_DELAY)) i_ctl (
    .clk(clk), .rstN(rstN), .ibf(ibf), .cmdFlag(cmdFlag),
    .inByte(inByte), .strobe(strobe)
  );

  assign hostRdata = portSel ? statusByte : dataOut;
endmodule

// File: rtl/ecHostPortChk.sv
module ecHostPortChk #(
  parameter int PROC_DELAY = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostWr,
  input logic       hostRd,
  input logic       portSel,
  input logic [7:0] statusByte
);
  localparam int AGE_W = $clog2(PROC_DELAY + 2);

  logic             ibf, obf, cmdBit, burst;
  logic [AGE_W-1:0] ibfAge;

  assign obf    = statusByte[0];
  assign ibf    = statusByte[1];
  assign cmdBit = statusByte[3];
  assign burst  = statusByte[4];

  always_ff @(posedge clk) begin
    if (!rstN || !ibf) ibfAge <= '0;
    else ibfAge <= ibfAge + 1'b1;
  end

  // R2
  ibf_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && !ibf |=> ibf);

  // R2
  cmd_bit_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && !ibf |=> cmdBit == $past(portSel));

  // R3
  ibf_max_age_chk: assert property (@(posedge clk) disable iff (!rstN)
    ibf |-> ibfAge < AGE_W'(PROC_DELAY));

  // R3
  ibf_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ibf && ibfAge == AGE_W'(PROC_DELAY - 1) |=> !ibf);

  // R4
  obf_with_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(obf) |-> $fell(ibf));

  // R6
  obf_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && !portSel && !ibf |=> !obf);

  // R7
  burst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ibf |=> burst == $past(burst));
endmodule

bind ecHostPort ecHostPortChk #(.PROC_DELAY(PROC_DELAY)) u_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
  .portSel(portSel), .statusByte(statusByte)
);

// File: tb/test_ecHostPort.sv
`timescale 1ns/100ps
module test_ecHostPort;
  localparam int PROC_DELAY = 3;
  localparam int NV = 33;
  // {kind, byte, expected}: kind 0 command, 1 data, 2 read data port
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h81, 8'h00}, {2'd1, 8'h10, 8'h00}, {2'd1, 8'hA5, 8'h00}, // R5
    {2'd0, 8'h81, 8'h00}, {2'd1, 8'hFF, 8'h00}, {2'd1, 8'h3C, 8'h00}, // R5
    {2'd0, 8'h80, 8'h00}, {2'd1, 8'h10, 8'h00}, {2'd2, 8'h00, 8'hA5}, // R4
    {2'd0, 8'h80, 8'h00}, {2'd1, 8'hFF, 8'h00}, {2'd2, 8'h00, 8'h3C}, // R4
    {2'd0, 8'h80, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd2, 8'h00, 8'h00}, // R1
    {2'd0, 8'h84, 8'h00}, {2'd2, 8'h00, 8'h00},                       // R8
    {2'd0, 8'h82, 8'h00}, {2'd2, 8'h00, 8'h90},                       // R7
    {2'd0, 8'h83, 8'h00},                                             // R7
    {2'd1, 8'h10, 8'h00},                                             // R9 stray
    {2'd0, 8'h81, 8'h00}, {2'd1, 8'h10, 8'h00},                       // R10 abort
    {2'd0, 8'h80, 8'h00}, {2'd1, 8'h10, 8'h00}, {2'd2, 8'h00, 8'hA5},
    {2'd0, 8'h81, 8'h00}, {2'd1, 8'h20, 8'h00},                       // R10 unknown
    {2'd0, 8'h99, 8'h00}, {2'd1, 8'h44, 8'h00},
    {2'd0, 8'h80, 8'h00}, {2'd1, 8'h20, 8'h00}, {2'd2, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic       portSel = 1'b1;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  int         nChk = 0;
  int         nBad = 0;
  int         cycles = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  ecHostPort #(.PROC_DELAY(PROC_DELAY), .ADDR_W(8)) i_ecHostPort (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .portSel(portSel), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic readStatus(output logic [7:0] s);
    portSel = 1'b1;
    #1 s = hostRdata;
  endtask

  task automatic pollStatus(input int bitIdx, input logic want);
    logic [7:0] s;
    for (int k = 0; k < 50; k++) begin
      readStatus(s);
      if (s[bitIdx] == want) return;
      @(negedge clk);
    end
    check("poll", s[bitIdx], want);
  endtask

  task automatic hostWrite(input logic port, input logic [7:0] b);
    @(negedge clk);
    pollStatus(1, 1'b0);
    @(negedge clk);
    portSel = port; hostWdata = b; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; portSel = 1'b1;
  endtask

  task automatic hostReadData(input string req, input logic [7:0] exp);
    @(negedge clk);
    pollStatus(0, 1'b1);
    @(negedge clk);
    portSel = 1'b0; hostRd = 1'b1;
    #1 check(req, hostRdata, exp);
    @(negedge clk);
    hostRd = 1'b0; portSel = 1'b1;
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finishRun();
    end
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    readStatus(s);
    check("R1 status", s, 8'h00);
    portSel = 1'b0;
    #1 check("R1 data", hostRdata, 8'h00);
    portSel = 1'b1;
    rstN = 1'b1;

    // R2 / R3: IBF timing, command bit, dropped write
    @(negedge clk);
    portSel = 1'b1; hostWdata = 8'h83; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    readStatus(s);
    check("R2 ibf+cmd", s, 8'h0A);
    portSel = 1'b0; hostWdata = 8'h55; hostWr = 1'b1;   // R3 dropped while busy
    @(negedge clk);
    hostWr = 1'b0;
    readStatus(s);
    check("R3 drop keeps cmd bit", s, 8'h0A);
    @(negedge clk);
    readStatus(s);
    check("R3 ibf last cycle", s, 8'h0A);
    @(negedge clk);
    readStatus(s);
    check("R3 ibf cleared", s, 8'h08);

    // R2 data port write clears command bit
    @(negedge clk);
    portSel = 1'b0; hostWdata = 8'h12; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    readStatus(s);
    check("R2 data bit3", s, 8'h02);
    repeat (PROC_DELAY) @(negedge clk);
    readStatus(s);
    check("R9 idle data ignored", s, 8'h00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][17:16])
        2'd0: hostWrite(1'b1, VEC[v][15:8]);
        2'd1: hostWrite(1'b0, VEC[v][15:8]);
        default: hostReadData($sformatf("R4/R5/R7/R8/R10 vec%0d", v), VEC[v][7:0]);
      endcase
    end

    // R7 burst status, R6 status read keeps OBF
    hostWrite(1'b1, 8'h82);
    pollStatus(1, 1'b0);
    readStatus(s);
    check("R7 burst status", s, 8'h19);
    @(negedge clk);
    readStatus(s);
    check("R6 status read keeps OBF", s, 8'h19);
    hostReadData("R7 ack", 8'h90);
    readStatus(s);
    check("R6 OBF cleared", s, 8'h18);
    hostWrite(1'b1, 8'h83);
    pollStatus(1, 1'b0);
    readStatus(s);
    check("R7 burst off", s, 8'h08);

    // R9 stray data leaves OBF clear and memory intact
    hostWrite(1'b0, 8'hFF);
    pollStatus(1, 1'b0);
    readStatus(s);
    check("R9 no OBF", s, 8'h00);
    hostWrite(1'b1, 8'h80);
    hostWrite(1'b0, 8'hFF);
    hostReadData("R9 memory intact", 8'h3C);

    done = 1'b1;
    finishRun();
  end
endmodule